// File: doc/BRIEF.md
# Snoop Command Phase Sequencer

The sequencer paces one accepted bus command through the five steps of its command phase: issue, reflection, snoop response, combined response and final response. Each step is held for a number of bus cycles that depends on whether the command is coherent and on how far the initiator sits from the root of the address-concentrator tree. Snoop logic and coherence state belong to other blocks, which read this one's stage code, entry strobes and done pulse to know when to act.

A command is launched with a one-cycle start pulse, together with the coherent flag and the concentrator level. Both values are captured at launch. While a command is in flight the block reports busy and ignores further starts. One cycle after the last response cycle it pulses done and is idle again.

Top module: `cmd_phase_seq`

## Requirements
- R1: Stages follow a fixed order, with codes 0 idle, 1 issue, 2 reflection, 3 snoop response, 4 combined response and 5 final response. Bit k of `stage_stb_o` is high only in the first cycle of stage code k+1, and at most one bit is high at a time.
- R2: The issue stage lasts 11 cycles when the command is coherent and 3 when it is not.
- R3: Reflection lasts 3, 5 or 7 cycles for `level_i` values 0, 1 and 2, where 0 is the level nearest the root. A value of 3 is treated as level 2.
- R4: The snoop response stage lasts 13 cycles whether or not the command is coherent.
- R5: The combined response stage lasts 9 cycles when the command is coherent and 5 when it is not.
- R6: The final response stage lasts 3 cycles. At level 2 the full command phase lasts 43 cycles when coherent and 31 when not.
- R7: A start seen at a clock edge while idle makes the stage code issue in the next cycle.
- R8: Starts received while busy are ignored. The coherent flag and level used are those present at launch, and later changes on them have no effect.
- R9: In the cycle after the last final-response cycle, `done_o` is high for exactly one cycle, the stage code is idle and `busy_o` is low. A start sampled in that cycle launches a new command.
- R10: During and straight after reset the stage code is idle, and busy, done and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch pulse for a command |
| coherent_i | input | 1 | Command is coherent |
| level_i | input | LVL_W | Initiator concentrator level, 0 nearest the root |
| stage_o | output | 3 | Current stage code |
| stage_stb_o | output | 5 | One-cycle entry strobe for each stage |
| busy_o | output | 1 | A command is in flight |
| done_o | output | 1 | One-cycle pulse when the command phase completes |

## Verification
The assertions assume that `start_i`, `coherent_i` and `level_i` change only away from the clock edge and are known whenever start is high. They also assume that reset is released only while start is low. The stimulus changes inputs on the falling edge and holds start low through reset. It sweeps every pairing of coherent flag and level, including the out-of-range level 3, and repeats each pairing while start pulses and the flag and level change during a busy command. It also chains commands so that a new start arrives in the done cycle.

// File: rtl/cmd_phase_pkg.sv
package cmd_phase_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ISSUE = 3'd1,
    PH_REFL  = 3'd2,
    PH_SNOOP = 3'd3,
    PH_COMB  = 3'd4,
    PH_FINAL = 3'd5
  } phase_e;

  localparam int unsigned NUM_PHASES = 5;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cmd_phase_dur.sv
module cmd_phase_dur
  import cmd_phase_pkg::*;
#(
  parameter int unsigned LVL_W      = 2,
  parameter int unsigned LEVELS     = 3,
  parameter int unsigned ISSUE_COH  = 11,
  parameter int unsigned ISSUE_NC   = 3,
  parameter int unsigned REFL_BASE  = 3,
  parameter int unsigned REFL_STEP  = 2,
  parameter int unsigned SNOOP_CYC  = 13,
  parameter int unsigned COMB_COH   = 9,
  parameter int unsigned COMB_NC    = 5,
  parameter int unsigned FINAL_CYC  = 3,
  parameter int unsigned CNT_W      = 4
) (
  input  phase_e             phase_i,
  input  logic               coh_i,
  input  logic [LVL_W-1:0]   lvl_i,
  output logic [CNT_W-1:0]   dur_o
);

  localparam int unsigned LVL_TOP = LEVELS - 1;

  int unsigned lvl_eff;
  int unsigned dur;

  always_comb begin
    // levels past the deepest one clamp to it
    lvl_eff = (int'(lvl_i) > int'(LVL_TOP)) ? LVL_TOP : int'(lvl_i);
    unique case (phase_i)
      PH_ISSUE: dur = coh_i ? ISSUE_COH : ISSUE_NC;
      PH_REFL:  dur = REFL_BASE + REFL_STEP * lvl_eff;
      PH_SNOOP: dur = SNOOP_CYC;
      PH_COMB:  dur = coh_i ? COMB_COH : COMB_NC;
      PH_FINAL: dur = FINAL_CYC;
      default:  dur = 1;
    endcase
    dur_o = dur[CNT_W-1:0];
  end

endmodule

// File: rtl/cmd_phase_timer.sv
module cmd_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] dur_i,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= dur_i - CNT_W'(1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign last_o = (cnt_q == '0);

endmodule

// File: rtl/cmd_phase_ctrl.sv
module cmd_phase_ctrl
  import cmd_phase_pkg::*;
#(
  parameter int unsigned LVL_W = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  coh_i,
  input  logic [LVL_W-1:0]      lvl_i,
  input  logic                  last_i,
  output phase_e                phase_o,
  output phase_e                nxt_phase_o,
  output logic                  load_o,
  output logic                  cfg_coh_o,
  output logic [LVL_W-1:0]      cfg_lvl_o,
  output logic [NUM_PHASES-1:0] stb_o,
  output logic                  done_o
);

  phase_e                phase_q, nxt;
  logic                  coh_q;
  logic [LVL_W-1:0]      lvl_q;
  logic [NUM_PHASES-1:0] stb_q;
  logic                  done_q;
  logic                  idle, advance;

  assign idle    = (phase_q == PH_IDLE);
  assign advance = idle ? start_i : last_i;

  always_comb begin
    unique case (phase_q)
      PH_IDLE:  nxt = PH_ISSUE;
      PH_ISSUE: nxt = PH_REFL;
      PH_REFL:  nxt = PH_SNOOP;
      PH_SNOOP: nxt = PH_COMB;
      PH_COMB:  nxt = PH_FINAL;
      default:  nxt = PH_IDLE;
    endcase
  end

  // launch uses live inputs, later stages the captured ones
  assign cfg_coh_o = idle ? coh_i : coh_q;
  assign cfg_lvl_o = idle ? lvl_i : lvl_q;
  assign load_o    = advance && (nxt != PH_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      coh_q   <= 1'b0;
      lvl_q   <= '0;
      stb_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      if (advance) phase_q <= nxt;
      if (idle && start_i) begin
        coh_q <= coh_i;
        lvl_q <= lvl_i;
      end
      stb_q  <= load_o ? NUM_PHASES'(1) << (int'(nxt) - 1) : '0;
      done_q <= advance && (phase_q == PH_FINAL);
    end
  end

  assign phase_o     = phase_q;
  assign nxt_phase_o = nxt;
  assign stb_o       = stb_q;
  assign done_o      = done_q;

endmodule

// File: rtl/cmd_phase_seq.sv
module cmd_phase_seq
  import cmd_phase_pkg::*;
#(
  parameter int unsigned LVL_W     = 2,
  parameter int unsigned LEVELS    = 3,
  parameter int unsigned ISSUE_COH = 11,
  parameter int unsigned ISSUE_NC  = 3,
  parameter int unsigned REFL_BASE = 3,
  parameter int unsigned REFL_STEP = 2,
  parameter int unsigned SNOOP_CYC = 13,
  parameter int unsigned COMB_COH  = 9,
  parameter int unsigned COMB_NC   = 5,
  parameter int unsigned FINAL_CYC = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  coherent_i,
  input  logic [LVL_W-1:0]      level_i,
  output logic [2:0]            stage_o,
  output logic [NUM_PHASES-1:0] stage_stb_o,
  output logic                  busy_o,
  output logic                  done_o
);

  localparam int unsigned REFL_MAX = REFL_BASE + REFL_STEP * (LEVELS - 1);
  localparam int unsigned MAX_DUR  = max2(max2(max2(ISSUE_COH, ISSUE_NC), max2(REFL_MAX, SNOOP_CYC)),
                                          max2(max2(COMB_COH, COMB_NC), FINAL_CYC));
  localparam int unsigned CNT_W    = $clog2(MAX_DUR + 1);

  phase_e           phase, nxt_phase;
  logic             load, last, cfg_coh;
  logic [LVL_W-1:0] cfg_lvl;
  logic [CNT_W-1:0] dur;

  cmd_phase_ctrl #(.LVL_W(LVL_W)) ctrl_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .coh_i       (coherent_i),
    .lvl_i       (level_i),
    .last_i      (last),
    .phase_o     (phase),
    .nxt_phase_o (nxt_phase),
    .load_o      (load),
    .cfg_coh_o   (cfg_coh),
    .cfg_lvl_o   (cfg_lvl),
    .stb_o       (stage_stb_o),
    .done_o      (done_o)
  );

  cmd_phase_dur #(
    .LVL_W(LVL_W), .LEVELS(LEVELS), .ISSUE_COH(ISSUE_COH), .ISSUE_NC(ISSUE_NC),
    .REFL_BASE(REFL_BASE), .REFL_STEP(REFL_STEP), .SNOOP_CYC(SNOOP_CYC),
    .COMB_COH(COMB_COH), .COMB_NC(COMB_NC), .FINAL_CYC(FINAL_CYC), .CNT_W(CNT_W)
  ) dur_i (
    .phase_i (nxt_phase),
    .coh_i   (cfg_coh),
    .lvl_i   (cfg_lvl),
    .dur_o   (dur)
  );

  cmd_phase_timer #(.CNT_W(CNT_W)) timer_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .dur_i  (dur),
    .last_o (last)
  );

  assign stage_o = phase;
  assign busy_o  = (phase != PH_IDLE);

endmodule

// File: rtl/cmd_phase_chk.sv
module cmd_phase_chk #(
  parameter int unsigned SNOOP_CYC = 13
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic [2:0] stage_o,
  input logic [4:0] stage_stb_o,
  input logic       busy_o,
  input logic       done_o
);

  logic [2:0] prev_q;
  logic [7:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 3'd0;
      run_q  <= 8'd0;
    end else begin
      prev_q <= stage_o;
      if (stage_o != prev_q) run_q <= 8'd1;
      else if (run_q != 8'hff) run_q <= run_q + 8'd1;
    end
  end

  AST_STB_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(stage_stb_o)) else $error("AST_STB_ONEHOT");                      // R1

  AST_STB_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_stb_o != 5'd0) |-> (stage_o == 3'($past(stage_o) + 3'd1)))
    else $error("AST_STB_ORDER");                                               // R1

  AST_START_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_o == 3'd0 && start_i) |=> (stage_o == 3'd1 && stage_stb_o[0]))
    else $error("AST_START_ACCEPT");                                            // R7

  AST_SNOOP_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_q == 3'd3 && stage_o != 3'd3) |-> (run_q == 8'(SNOOP_CYC)))
    else $error("AST_SNOOP_LEN");                                               // R4

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o) else $error("AST_DONE_PULSE");                          // R9

  AST_DONE_FROM_FINAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(stage_o) == 3'd5 && stage_o == 3'd0 && !busy_o))
    else $error("AST_DONE_FROM_FINAL");                                         // R9

endmodule

bind cmd_phase_seq cmd_phase_chk #(.SNOOP_CYC(SNOOP_CYC)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .stage_o     (stage_o),
  .stage_stb_o (stage_stb_o),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/cmd_phase_seq_tb.sv
module cmd_phase_seq_tb_top;

  localparam time CLK_PERIOD = 10ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       coherent_i = 1'b0;
  logic [1:0] level_i = 2'd0;
  logic [2:0] stage_o;
  logic [4:0] stage_stb_o;
  logic       busy_o;
  logic       done_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cmd_phase_seq dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .coherent_i  (coherent_i),
    .level_i     (level_i),
    .stage_o     (stage_o),
    .stage_stb_o (stage_stb_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_dur(input int s, input bit coh, input int lvl);
    int l = (lvl > 2) ? 2 : lvl;
    case (s)
      1: return coh ? 11 : 3;
      2: return 3 + 2 * l;
      3: return 13;
      4: return coh ? 9 : 5;
      default: return 3;
    endcase
  endfunction

  function automatic string stage_tag(input int s);
    case (s)
      1: return "R2 issue length";
      2: return "R3 reflection length";
      3: return "R4 snoop length";
      4: return "R5 combined length";
      default: return "R6 final length";
    endcase
  endfunction

  task automatic launch(input bit coh, input int lvl);
    start_i    = 1'b1;
    coherent_i = coh;
    level_i    = 2'(lvl);
    @(negedge clk_i);
  endtask

  // called at the negedge of the first issue cycle
  task automatic follow(input bit coh, input int lvl, input bit disturb,
                        input bit chain, input bit ncoh, input int nlvl);
    int tot = 0;
    int stb_bad = 0;
    check(stage_o == 3'd1 && busy_o, "R7 issue after start", int'(stage_o), 1);
    for (int s = 1; s <= 5; s++) begin
      int d = exp_dur(s, coh, lvl);
      int len_bad = 0;
      for (int k = 0; k < d; k++) begin
        logic [4:0] stb_exp = (k == 0) ? 5'(1 << (s - 1)) : 5'd0;
        if (stage_o != 3'(s) || !busy_o || done_o) len_bad++;
        if (stage_stb_o != stb_exp) stb_bad++;
        if (disturb && tot < 20) begin
          start_i    = 1'b1;
          coherent_i = ~coh;
          level_i    = (lvl == 0) ? 2'd3 : 2'd0;
        end else begin
          start_i = 1'b0;
        end
        tot++;
        @(negedge clk_i);
      end
      check(len_bad == 0, stage_tag(s), len_bad, 0);
    end
    check(stb_bad == 0, "R1 entry strobes", stb_bad, 0);
    if (lvl >= 2)
      check(tot == (coh ? 43 : 31), "R6 total length", tot, coh ? 43 : 31);
    if (disturb)
      check(stage_o == 3'd0 && done_o, "R8 busy start ignored", int'(stage_o), 0);
    check(done_o && stage_o == 3'd0 && !busy_o && stage_stb_o == 5'd0,
          "R9 done cycle", int'(done_o), 1);
    if (chain) begin
      launch(ncoh, nlvl);
    end else begin
      start_i = 1'b0;
      @(negedge clk_i);
      check(!done_o && stage_o == 3'd0 && !busy_o, "R9 done single cycle", int'(done_o), 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2);
    check(stage_o == 3'd0 && !busy_o && !done_o && stage_stb_o == 5'd0,
          "R10 in reset", int'(stage_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    check(stage_o == 3'd0 && !busy_o && !done_o && stage_stb_o == 5'd0,
          "R10 after reset", int'(stage_o), 0);

    // sweep flag and level, quiet and disturbed
    for (int dis = 0; dis < 2; dis++) begin
      for (int c = 0; c < 2; c++) begin
        for (int l = 0; l < 4; l++) begin
          launch(c[0], l);
          follow(c[0], l, dis[0], 1'b0, 1'b0, 0);
          repeat (2) @(negedge clk_i);
        end
      end
    end

    // back-to-back: start in the done cycle
    launch(1'b0, 2);
    follow(1'b0, 2, 1'b0, 1'b1, 1'b1, 1);
    follow(1'b1, 1, 1'b0, 1'b1, 1'b0, 0);
    follow(1'b0, 0, 1'b0, 1'b0, 1'b0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule